// File: doc/BRIEF.md
# I2C Alias Address Translator

This block sits on a local I2C bus as a slave and serves as the front end of a link bridge. After every START it collects the 7-bit address and the R/W bit. It then classifies the transaction in one of three ways. The first is the block's own local address, which it acknowledges itself. The second is a remote target, either the remote bridge or a remote slave reached through an alias table. The third is a miss, which is left unacknowledged. For a remote target it swaps the alias for the real remote address and raises a forwarding request toward the link layer. It holds SCL low from the end of the eighth bit until the link layer answers. The answer is then placed in the ninth-bit slot as ACK or NACK, and SCL is released.

Software programs the table through a simple write port. That port sets the pass-through enable, the local address, the remote-bridge ID and its alias, and up to `N_ENTRIES` alias entries, each holding a real remote slave ID, an alias ID and a valid bit. The remote-bridge ID is captured from the link layer when the link lock indication rises. SCL and SDA are open-drain: the block samples the line levels and only ever pulls low through enable outputs.

Top module: `i2c_xlat`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe` and `fwd_req` are low.
- R2: An address equal to the local address (reset 0x60, 7-bit, R/W excluded) is acknowledged by driving `sda_oe` from the falling SCL edge after the R/W bit until the next falling edge. It is never forwarded, whatever the pass-through enable holds.
- R3: With pass-through enabled (write address 0, data bit 0), an address equal to the alias of a valid entry raises `fwd_req` with `fwd_addr` set to that entry's real ID and `fwd_rw` equal to the received R/W bit. Entries are written at address 8+i with data bits [6:0] real ID, [13:7] alias, [14] valid.
- R4: An entry whose alias equals its real ID forwards the address unchanged.
- R5: With pass-through disabled, no address other than the local one is forwarded or acknowledged.
- R6: An entry whose valid bit is clear never matches.
- R7: The remote bridge is reached through a bridge alias (write address 3, bits [13:7] alias, bit 14 valid). It forwards to the bridge ID only once that ID is set, either by a write to address 2 or by capture of `remote_bridge_id` on a rising `link_lock`.
- R8: While a forward is pending, `scl_oe` is high and `fwd_addr`/`fwd_rw` stay stable until `fwd_ack`.
- R9: On `fwd_ack`, `fwd_req` drops and SDA is driven low for the ninth bit when `fwd_nack` is low, or left released when it is high, before SCL is released.
- R10: An address that matches nothing is not acknowledged and is not forwarded.
- R11: A START or STOP seen while a forward is pending drops `fwd_req` and releases SCL on the next cycle.
- R12: The local address wins over any alias, and among entries with the same alias the lowest index wins.
- R13: A START in the middle of an address byte restarts the address collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low (stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register write address |
| reg_wdata | input | REG_DW | Register write data |
| link_lock | input | 1 | Link lock indication |
| remote_bridge_id | input | 7 | Remote bridge ID captured on lock |
| fwd_req | output | 1 | Forward request to the link layer |
| fwd_addr | output | 7 | Translated remote address |
| fwd_rw | output | 1 | R/W bit carried with the request |
| fwd_ack | input | 1 | Link-layer response strobe |
| fwd_nack | input | 1 | Remote NACK, valid with `fwd_ack` |

## Verification
The verdict, `sda_oe` for a local hit or `fwd_req` with `scl_oe` for a remote hit, is registered on the first clock that sees the falling SCL edge after the R/W bit. The bench samples it three clocks after driving that edge. A `fwd_ack` clears the request and sets `sda_oe` on the following edge, and SCL is released one edge later, so the bench samples three clocks after the strobe. The ninth-bit SDA level is read two clocks into the high phase of SCL, and the release of `sda_oe` three clocks after the falling edge. An abort by START or STOP is observed three clocks after the condition.

// File: rtl/i2c_xlat_pkg.sv
package i2c_xlat_pkg;
    localparam int ADDR_W = 7;

    typedef logic [ADDR_W-1:0] addr7_t;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_LOCAL,
        HIT_REMOTE
    } hit_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_RELEASE,
        ST_ACK,
        ST_SKIP
    } st_e;

    typedef struct packed {
        logic   valid;
        addr7_t alias_id;
        addr7_t real_id;
    } alias_ent_t;
endpackage

// File: rtl/i2c_xlat_cond.sv
module i2c_xlat_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_p,
    output logic stop_p,
    output logic rise_p,
    output logic fall_p
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d.scl = scl_i;
        line_d.sda = sda_i;
        start_p = scl_i & line_q.scl & line_q.sda & ~sda_i;
        stop_p  = scl_i & line_q.scl & ~line_q.sda & sda_i;
        rise_p  = scl_i & ~line_q.scl;
        fall_p  = ~scl_i & line_q.scl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '{scl: 1'b1, sda: 1'b1};
        else        line_q <= line_d;
    end
endmodule

// File: rtl/i2c_xlat_regs.sv
module i2c_xlat_regs
    import i2c_xlat_pkg::*;
#(
    parameter int     N_ENTRIES = 8,
    parameter addr7_t OWN_RESET = 7'h60,
    localparam int    REG_AW    = $clog2(N_ENTRIES) + 1,
    localparam int    IDX_W     = REG_AW - 1,
    localparam int    REG_DW    = 2 * ADDR_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [REG_AW-1:0]            reg_addr,
    input  logic [REG_DW-1:0]            reg_wdata,
    input  logic                         link_lock,
    input  addr7_t                       remote_bridge_id,
    output logic                         pass_en,
    output addr7_t                       own_addr,
    output addr7_t                       bridge_id,
    output addr7_t                       bridge_alias,
    output logic                         bridge_ok,
    output alias_ent_t [N_ENTRIES-1:0]   ent
);
    typedef struct packed {
        logic                       pass_en;
        addr7_t                     own;
        addr7_t                     bid;
        logic                       bid_set;
        addr7_t                     balias;
        logic                       balias_v;
        logic                       lock_prev;
        alias_ent_t [N_ENTRIES-1:0] ent;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.lock_prev = link_lock;
        if (link_lock && !r_q.lock_prev) begin
            r_d.bid     = remote_bridge_id;
            r_d.bid_set = 1'b1;
        end
        if (reg_we) begin
            if (reg_addr[REG_AW-1]) begin
                for (int i = 0; i < N_ENTRIES; i++) begin
                    if (reg_addr[IDX_W-1:0] == IDX_W'(i)) begin
                        r_d.ent[i].real_id  = reg_wdata[ADDR_W-1:0];
                        r_d.ent[i].alias_id = reg_wdata[2*ADDR_W-1:ADDR_W];
                        r_d.ent[i].valid    = reg_wdata[2*ADDR_W];
                    end
                end
            end else if (reg_addr == REG_AW'(0)) begin
                r_d.pass_en = reg_wdata[0];
            end else if (reg_addr == REG_AW'(1)) begin
                r_d.own = reg_wdata[ADDR_W-1:0];
            end else if (reg_addr == REG_AW'(2)) begin
                r_d.bid     = reg_wdata[ADDR_W-1:0];
                r_d.bid_set = 1'b1;
            end else if (reg_addr == REG_AW'(3)) begin
                r_d.balias   = reg_wdata[2*ADDR_W-1:ADDR_W];
                r_d.balias_v = reg_wdata[2*ADDR_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.own <= OWN_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign pass_en      = r_q.pass_en;
    assign own_addr     = r_q.own;
    assign bridge_id    = r_q.bid;
    assign bridge_alias = r_q.balias;
    assign bridge_ok    = r_q.bid_set & r_q.balias_v;
    assign ent          = r_q.ent;
endmodule

// File: rtl/i2c_xlat_match.sv
module i2c_xlat_match
    import i2c_xlat_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  addr7_t                     addr,
    input  addr7_t                     own_addr,
    input  logic                       pass_en,
    input  logic                       bridge_ok,
    input  addr7_t                     bridge_id,
    input  addr7_t                     bridge_alias,
    input  alias_ent_t [N_ENTRIES-1:0] ent,
    output hit_e                       hit,
    output addr7_t                     target
);
    logic [N_ENTRIES-1:0] ent_hit;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign ent_hit[g] = ent[g].valid && (ent[g].alias_id == addr);
    end

    always_comb begin
        addr7_t ent_tgt;
        logic   any_ent;
        ent_tgt = '0;
        any_ent = 1'b0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (ent_hit[i]) begin
                ent_tgt = ent[i].real_id;
                any_ent = 1'b1;
            end
        end

        hit    = HIT_NONE;
        target = '0;
        if (addr == own_addr) begin
            hit = HIT_LOCAL;
        end else if (pass_en) begin
            if (bridge_ok && (addr == bridge_alias)) begin
                hit    = HIT_REMOTE;
                target = bridge_id;
            end else if (any_ent) begin
                hit    = HIT_REMOTE;
                target = ent_tgt;
            end
        end
    end
endmodule

// File: rtl/i2c_xlat.sv
module i2c_xlat
    import i2c_xlat_pkg::*;
#(
    parameter int     N_ENTRIES = 8,
    parameter addr7_t OWN_RESET = 7'h60,
    localparam int    REG_AW    = $clog2(N_ENTRIES) + 1,
    localparam int    REG_DW    = 2 * ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              link_lock,
    input  logic [6:0]        remote_bridge_id,
    output logic              fwd_req,
    output logic [6:0]        fwd_addr,
    output logic              fwd_rw,
    input  logic              fwd_ack,
    input  logic              fwd_nack
);
    localparam int SH_W  = ADDR_W + 1;
    localparam int CNT_W = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] BITS = CNT_W'(SH_W);

    typedef struct packed {
        st_e             st;
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0] sh;
        logic            scl_oe;
        logic            sda_oe;
        logic            req;
        addr7_t          tgt;
        logic            rw;
    } fsm_t;

    fsm_t s_d, s_q;

    logic start_p, stop_p, rise_p, fall_p;
    logic pass_en, bridge_ok;
    addr7_t own_addr, bridge_id, bridge_alias, tgt;
    alias_ent_t [N_ENTRIES-1:0] ent;
    hit_e hit;

    i2c_xlat_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_p (start_p),
        .stop_p  (stop_p),
        .rise_p  (rise_p),
        .fall_p  (fall_p)
    );

    i2c_xlat_regs #(
        .N_ENTRIES (N_ENTRIES),
        .OWN_RESET (OWN_RESET)
    ) u_regs (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_we           (reg_we),
        .reg_addr         (reg_addr),
        .reg_wdata        (reg_wdata),
        .link_lock        (link_lock),
        .remote_bridge_id (remote_bridge_id),
        .pass_en          (pass_en),
        .own_addr         (own_addr),
        .bridge_id        (bridge_id),
        .bridge_alias     (bridge_alias),
        .bridge_ok        (bridge_ok),
        .ent              (ent)
    );

    i2c_xlat_match #(
        .N_ENTRIES (N_ENTRIES)
    ) u_match (
        .addr         (s_q.sh[SH_W-1:1]),
        .own_addr     (own_addr),
        .pass_en      (pass_en),
        .bridge_ok    (bridge_ok),
        .bridge_id    (bridge_id),
        .bridge_alias (bridge_alias),
        .ent          (ent),
        .hit          (hit),
        .target       (tgt)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_ADDR: begin
                if (rise_p && (s_q.cnt != BITS)) begin
                    s_d.sh  = {s_q.sh[SH_W-2:0], sda_i};
                    s_d.cnt = s_q.cnt + 1'b1;
                end else if (fall_p && (s_q.cnt == BITS)) begin
                    unique case (hit)
                        HIT_LOCAL: begin
                            s_d.sda_oe = 1'b1;
                            s_d.st     = ST_ACK;
                        end
                        HIT_REMOTE: begin
                            s_d.scl_oe = 1'b1;
                            s_d.req    = 1'b1;
                            s_d.tgt    = tgt;
                            s_d.rw     = s_q.sh[0];
                            s_d.st     = ST_HOLD;
                        end
                        default: s_d.st = ST_SKIP;
                    endcase
                end
            end
            ST_HOLD: begin
                if (fwd_ack) begin
                    s_d.req    = 1'b0;
                    s_d.sda_oe = ~fwd_nack;
                    s_d.st     = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                s_d.scl_oe = 1'b0;
                s_d.st     = ST_ACK;
            end
            ST_ACK: begin
                if (fall_p) begin
                    s_d.sda_oe = 1'b0;
                    s_d.st     = ST_SKIP;
                end
            end
            default: ;
        endcase

        if (start_p || stop_p) begin
            s_d.st     = start_p ? ST_ADDR : ST_IDLE;
            s_d.cnt    = '0;
            s_d.scl_oe = 1'b0;
            s_d.sda_oe = 1'b0;
            s_d.req    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_oe   = s_q.scl_oe;
    assign sda_oe   = s_q.sda_oe;
    assign fwd_req  = s_q.req;
    assign fwd_addr = s_q.tgt;
    assign fwd_rw   = s_q.rw;
endmodule

// File: rtl/i2c_xlat_chk.sv
module i2c_xlat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_p,
    input logic       stop_p,
    input logic       pass_en,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       fwd_req,
    input logic       fwd_ack,
    input logic [6:0] fwd_addr,
    input logic       fwd_rw
);
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req && !fwd_ack && !start_p && !stop_p |=> fwd_req); // R8

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req && !fwd_ack && !start_p && !stop_p |=> $stable(fwd_addr) && $stable(fwd_rw)); // R8

    AST_STRETCH_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |-> scl_oe); // R8

    AST_FWD_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_req) |-> $past(pass_en)); // R5

    AST_NO_ACK_BEFORE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |-> !sda_oe); // R9

    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_p || stop_p |=> !fwd_req && !scl_oe); // R11
endmodule

bind i2c_xlat i2c_xlat_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .pass_en  (pass_en),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .fwd_req  (fwd_req),
    .fwd_ack  (fwd_ack),
    .fwd_addr (fwd_addr),
    .fwd_rw   (fwd_rw)
);

// File: tb/test_i2c_xlat.sv
module test_i2c_xlat;
    localparam int HALF = 4;
    localparam logic [6:0] OWN = 7'h60;
    localparam logic [6:0] BALIAS = 7'h59;
    localparam logic [6:0] BID_LOCK = 7'h58;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, bypass = 1'b0;
    logic scl_i, sda_i, scl_oe, sda_oe;
    logic reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [14:0] reg_wdata = '0;
    logic link_lock = 1'b0;
    logic [6:0] remote_bridge_id = BID_LOCK;
    logic fwd_req, fwd_rw;
    logic [6:0] fwd_addr;
    logic fwd_ack = 1'b0, fwd_nack = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic pass = 1'b0, bset = 1'b0;
    logic [6:0] ea [8];
    logic [6:0] er [8];
    logic       ev [8];

    always #2 clk = ~clk;

    assign scl_i = m_scl & (bypass | ~scl_oe);
    assign sda_i = m_sda & ~sda_oe;

    i2c_xlat i_i2c_xlat (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .link_lock(link_lock),
        .remote_bridge_id(remote_bridge_id), .fwd_req(fwd_req),
        .fwd_addr(fwd_addr), .fwd_rw(fwd_rw), .fwd_ack(fwd_ack),
        .fwd_nack(fwd_nack)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_w(input logic [3:0] a, input logic [14:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        wait_clk(1);
        reg_we = 1'b0;
    endtask

    task automatic t_start;
        m_sda = 1'b1; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(1);
    endtask

    task automatic t_bit(input logic b);
        m_sda = b; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(1);
    endtask

    task automatic t_stop;
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [6:0] a, input logic rw);
        for (int i = 6; i >= 0; i--) t_bit(a[i]);
        t_bit(rw);
        m_sda = 1'b1;
        wait_clk(3);
    endtask

    // kind: 0 miss, 1 local, 2 forwarded
    function automatic void model(input logic [6:0] a, output int kind,
                                  output logic [6:0] tgt, output string tag);
        kind = 0; tgt = '0; tag = "R10";
        if (a == OWN) begin
            kind = 1; tag = (ev[4] && ea[4] == a) ? "R12" : "R2";
            return;
        end
        if (!pass) begin tag = "R5"; return; end
        if (bset && a == BALIAS) begin kind = 2; tgt = BID_LOCK; tag = "R7"; return; end
        for (int i = 0; i < 8; i++) begin
            if (ev[i] && ea[i] == a) begin
                kind = 2; tgt = er[i];
                tag = (a == 7'h52) ? "R12" : (er[i] == a) ? "R4" : "R3";
                return;
            end
        end
        if (a == 7'h40) tag = "R6";
    endfunction

    task automatic xfer(input logic [6:0] a, input logic rw, input logic nack);
        int kind; logic [6:0] tgt; string tag; logic exp_ack;
        model(a, kind, tgt, tag);
        t_start;
        send_byte(a, rw);
        chk(sda_oe == (kind == 1), tag, sda_oe, kind == 1);
        chk(fwd_req == (kind == 2), tag, fwd_req, kind == 2);
        chk(scl_oe == (kind == 2), tag, scl_oe, kind == 2);
        exp_ack = (kind == 1);
        if (kind == 2) begin
            chk(fwd_addr == tgt, tag, fwd_addr, tgt);
            chk(fwd_rw == rw, tag, fwd_rw, rw);
            m_scl = 1'b1; wait_clk(4);
            chk(scl_i == 1'b0 && fwd_req, "R8", scl_i, 0);
            m_scl = 1'b0;
            fwd_ack = 1'b1; fwd_nack = nack;
            wait_clk(1);
            fwd_ack = 1'b0; fwd_nack = 1'b0;
            wait_clk(2);
            chk(!fwd_req && !scl_oe, "R9", {fwd_req, scl_oe}, 0);
            exp_ack = !nack;
        end
        m_scl = 1'b1; wait_clk(2);
        chk(sda_i == !exp_ack, (kind == 2) ? "R9" : tag, sda_i, !exp_ack);
        wait_clk(2);
        m_scl = 1'b0; wait_clk(3);
        chk(!sda_oe, "R9", sda_oe, 0);
        t_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        ea[0] = 7'h52; er[0] = 7'h50; ev[0] = 1'b1;
        ea[1] = 7'h53; er[1] = 7'h51; ev[1] = 1'b1;
        ea[2] = 7'h30; er[2] = 7'h30; ev[2] = 1'b1;
        ea[3] = 7'h52; er[3] = 7'h11; ev[3] = 1'b1;
        ea[4] = 7'h60; er[4] = 7'h22; ev[4] = 1'b1;
        ea[5] = 7'h40; er[5] = 7'h41; ev[5] = 1'b0;
        ea[6] = 7'h00; er[6] = 7'h00; ev[6] = 1'b0;
        ea[7] = 7'h00; er[7] = 7'h00; ev[7] = 1'b0;

        wait_clk(3);
        chk(!scl_oe && !sda_oe && !fwd_req, "R1", {scl_oe, sda_oe, fwd_req}, 0);
        rst_n = 1'b1;
        wait_clk(2);

        for (int i = 0; i < 8; i++) reg_w(4'(8 + i), {ev[i], ea[i], er[i]});
        reg_w(4'd3, {1'b1, BALIAS, 7'h00});
        reg_w(4'd0, 15'd1);
        pass = 1'b1;

        // bridge alias before lock: ID not yet set
        xfer(BALIAS, 1'b0, 1'b0);
        link_lock = 1'b1;
        wait_clk(2);
        bset = 1'b1;

        // sweep every address with pass-through on
        for (int a = 0; a < 128; a++) xfer(7'(a), a[0], a[1]);

        // abort a pending forward with a STOP
        t_start;
        send_byte(7'h53, 1'b1);
        chk(fwd_req && scl_oe, "R11", {fwd_req, scl_oe}, 3);
        bypass = 1'b1;
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b1; wait_clk(3);
        chk(!fwd_req && !scl_oe, "R11", {fwd_req, scl_oe}, 0);
        bypass = 1'b0;
        wait_clk(HALF);

        // repeated START in the middle of the address byte
        t_start;
        t_bit(1'b1); t_bit(1'b0); t_bit(1'b1);
        t_start;
        send_byte(OWN, 1'b0);
        chk(sda_oe, "R13", sda_oe, 1);
        m_scl = 1'b1; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(3);
        t_stop;

        // sweep every address with pass-through off
        reg_w(4'd0, 15'd0);
        pass = 1'b0;
        for (int a = 0; a < 128; a++) xfer(7'(a), a[0], 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule